// File: doc/BRIEF.md
# Parity-Coded Self-Checking Step Counter

This block is a free-running counter built from a 4-bit maximal-length shift register. A fifth bit, the even-parity bit of the four information bits, is stored alongside them, so every value the register holds is a nonzero word of the 5-bit even-weight code. Stepping walks the 15 nonzero codewords in a fixed ring and never enters the all-zero word.

The observed word feeds an embedded two-rail checker that splits it into two groups and computes the parity of each group. The second rail is inverted, so a correct word gives complementary rails and an odd-weight word gives equal rails. A stuck-at on the checker's own output rail shows up as an invalid rail pair for some state in the ring, so a checker fault is found in normal use and is not left as an unchecked hard core.

A synchronous reset loads a fixed seed. A load port replaces the state with a supplied codeword. Fault-injection inputs can force any observed state bit or either checker rail to a chosen value. This lets a bench show that errors are detected.

Top module: `pcode_lfsr_counter`

## Requirements
- R1: When `rst` is high at a clock edge, the stored state becomes the seed parameter `SEED` (default 5'b00011), and the rails are complementary with no fault forced.
- R2: Once reset has been applied, the stored state is never 5'b00000 and always has an even number of ones.
- R3: State bits [4:1] hold the information nibble and bit 0 holds its parity. A step shifts the nibble left by one and inserts bit3 XOR bit0 at the bottom, so the ring repeats after exactly 15 steps with no state seen twice.
- R4: With `step_en` and `load_en` both low, the state holds.
- R5: With `load_en` high and `load_word` a nonzero even-weight word, the state becomes `load_word` on the next edge. A load takes precedence over a step.
- R6: With `load_en` high and `load_word` either zero or of odd weight, the state keeps its previous value, whatever `step_en` is.
- R7: `err_rail[0]` is the XOR of observed bits [1:0] and `err_rail[1]` is the XNOR of observed bits [4:2]. With no fault forced, the rails read 01 or 10.
- R8: Forcing any one observed state bit to the inverse of its stored value makes the rails read 00 or 11.
- R9: With either checker rail stuck at 0 or at 1, stepping through the ring yields at least one state whose rail pair is 00 or 11.
- R10: Fault inputs act only on the observed word and on the rails. The stored state and its stepping are unaffected, and `state_q` equals the stored state again once the fault is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, loads `SEED` |
| load_en | input | 1 | Request to load `load_word` |
| load_word | input | 5 | Candidate codeword, bits [4:1] information and bit 0 parity |
| step_en | input | 1 | Advance one position in the ring |
| flt_state_en | input | 5 | Per-bit enable forcing an observed state bit |
| flt_state_val | input | 5 | Forced values for observed state bits |
| flt_rail_en | input | 2 | Per-rail enable forcing a checker rail |
| flt_rail_val | input | 2 | Forced values for the checker rails |
| state_q | output | 5 | Observed state word |
| err_rail | output | 2 | Two-rail check result, 01/10 valid and 00/11 error |

## Verification
The ring is walked from the reset seed for a full 15 steps. Recording every word shows the period and the absence of repeats, which separates a correct feedback tap from a short cycle. Loads are tried with a valid word while stepping is also requested, then with zero and with an odd-weight word, which separates accept, reject and step priority. Each state bit in turn is forced to its inverse, and each rail is held stuck at 0 and at 1 while the ring runs. These patterns separate the detection of a corrupted word from the self-testing of the checker. They also show that no fault reaches the stored state.

// File: rtl/pcode_pkg.sv
package pcode_pkg;
  localparam int INFO_W = 4;
  localparam int WORD_W = INFO_W + 1;
  localparam int SPLIT  = WORD_W / 2;
  localparam logic [INFO_W-1:0] TAP_MASK = 4'b1001;

  typedef logic [INFO_W-1:0] info_t;
  typedef logic [WORD_W-1:0] word_t;

  // attach even parity below the information nibble
  function automatic word_t encode(input info_t i);
    return {i, ^i};
  endfunction

  // one shift of the maximal-length register
  function automatic info_t advance(input info_t i);
    return {i[INFO_W-2:0], ^(i & TAP_MASK)};
  endfunction

  function automatic word_t next_word(input word_t w);
    return encode(advance(w[WORD_W-1:1]));
  endfunction

  function automatic logic is_code(input word_t w);
    return (w != '0) && !(^w);
  endfunction
endpackage

// File: rtl/pcode_next_state.sv
module pcode_next_state
  import pcode_pkg::*;
(
  input  word_t cur,
  output word_t nxt
);
  assign nxt = next_word(cur);
endmodule

// File: rtl/pcode_fault_mux.sv
module pcode_fault_mux #(
  parameter int W = 1
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] force_en,
  input  logic [W-1:0] force_val,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = force_en[i] ? force_val[i] : din[i];
  end
endmodule

// File: rtl/pcode_xor_tree.sv
module pcode_xor_tree #(
  parameter int W      = 2,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] din,
  output logic         dout
);
  logic [W-1:0] chain;
  assign chain[0] = din[0];
  for (genvar i = 1; i < W; i++) begin : g_stage
    assign chain[i] = chain[i-1] ^ din[i];
  end
  if (INVERT) begin : g_inv
    assign dout = ~chain[W-1];
  end else begin : g_true
    assign dout = chain[W-1];
  end
endmodule

// File: rtl/pcode_tsc_checker.sv
module pcode_tsc_checker
  import pcode_pkg::*;
(
  input  word_t       word,
  input  logic [1:0]  rail_force_en,
  input  logic [1:0]  rail_force_val,
  output logic [1:0]  rails
);
  logic [1:0] raw;

  pcode_xor_tree #(.W(SPLIT), .INVERT(1'b0)) u_low (
    .din (word[SPLIT-1:0]),
    .dout(raw[0])
  );

  pcode_xor_tree #(.W(WORD_W-SPLIT), .INVERT(1'b1)) u_high (
    .din (word[WORD_W-1:SPLIT]),
    .dout(raw[1])
  );

  pcode_fault_mux #(.W(2)) u_rail_flt (
    .din      (raw),
    .force_en (rail_force_en),
    .force_val(rail_force_val),
    .dout     (rails)
  );
endmodule

// File: rtl/pcode_lfsr_counter.sv
module pcode_lfsr_counter
  import pcode_pkg::*;
#(
  parameter logic [4:0] SEED = 5'b00011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic [4:0] load_word,
  input  logic       step_en,
  input  logic [4:0] flt_state_en,
  input  logic [4:0] flt_state_val,
  input  logic [1:0] flt_rail_en,
  input  logic [1:0] flt_rail_val,
  output logic [4:0] state_q,
  output logic [1:0] err_rail
);
  word_t state_reg;
  word_t step_word;
  logic  load_ok;

  assign load_ok = load_en && is_code(load_word);

  pcode_next_state u_next (
    .cur(state_reg),
    .nxt(step_word)
  );

  always_ff @(posedge clk) begin
    if (rst)                state_reg <= SEED;
    else if (load_en) begin
      if (load_ok)          state_reg <= load_word;
    end
    else if (step_en)       state_reg <= step_word;
  end

  pcode_fault_mux #(.W(WORD_W)) u_state_flt (
    .din      (state_reg),
    .force_en (flt_state_en),
    .force_val(flt_state_val),
    .dout     (state_q)
  );

  pcode_tsc_checker u_chk (
    .word          (state_q),
    .rail_force_en (flt_rail_en),
    .rail_force_val(flt_rail_val),
    .rails         (err_rail)
  );
endmodule

// File: rtl/pcode_lfsr_counter_sva.sv
module pcode_lfsr_counter_sva
  import pcode_pkg::*;
#(
  parameter logic [4:0] SEED = 5'b00011
) (
  input logic       clk,
  input logic       rst,
  input logic       load_en,
  input logic [4:0] load_word,
  input logic       step_en,
  input logic [4:0] flt_state_en,
  input logic [1:0] flt_rail_en,
  input logic [4:0] state_reg,
  input logic [4:0] state_q,
  input logic [1:0] err_rail
);
  logic started = 1'b0;
  always_ff @(posedge clk) if (rst) started <= 1'b1;

  assert_reset_seed_R1: assert property (@(posedge clk) disable iff (!started)
    rst |=> state_reg == SEED);

  assert_codeword_R2: assert property (@(posedge clk) disable iff (rst || !started)
    (state_reg != 5'b0) && !(^state_reg));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst || !started)
    (!load_en && step_en) |=> state_reg == next_word($past(state_reg)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst || !started)
    (!load_en && !step_en) |=> $stable(state_reg));

  assert_load_R5: assert property (@(posedge clk) disable iff (rst || !started)
    (load_en && load_word != 5'b0 && !(^load_word)) |=> state_reg == $past(load_word));

  assert_reject_R6: assert property (@(posedge clk) disable iff (rst || !started)
    (load_en && (load_word == 5'b0 || ^load_word)) |=> $stable(state_reg));

  assert_rails_valid_R7: assert property (@(posedge clk) disable iff (rst || !started)
    (flt_state_en == 5'b0 && flt_rail_en == 2'b0) |-> err_rail[1] != err_rail[0]);

  assert_detect_R8: assert property (@(posedge clk) disable iff (rst || !started)
    (flt_rail_en == 2'b0 && ^state_q) |-> err_rail[1] == err_rail[0]);

  assert_view_R10: assert property (@(posedge clk) disable iff (rst || !started)
    (flt_state_en == 5'b0) |-> state_q == state_reg);
endmodule

bind pcode_lfsr_counter pcode_lfsr_counter_sva #(.SEED(SEED)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .load_en     (load_en),
  .load_word   (load_word),
  .step_en     (step_en),
  .flt_state_en(flt_state_en),
  .flt_rail_en (flt_rail_en),
  .state_reg   (state_reg),
  .state_q     (state_q),
  .err_rail    (err_rail)
);

// File: tb/pcode_lfsr_counter_tb.sv
module pcode_lfsr_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] SEED_W = 5'b00011;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_word = '0;
  logic       step_en = 1'b0;
  logic [4:0] flt_state_en = '0;
  logic [4:0] flt_state_val = '0;
  logic [1:0] flt_rail_en = '0;
  logic [1:0] flt_rail_val = '0;
  logic [4:0] state_q;
  logic [1:0] err_rail;

  int checks = 0;
  int fails = 0;
  int ref_s = 0;
  bit done = 1'b0;

  pcode_lfsr_counter u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
    .step_en(step_en), .flt_state_en(flt_state_en), .flt_state_val(flt_state_val),
    .flt_rail_en(flt_rail_en), .flt_rail_val(flt_rail_val),
    .state_q(state_q), .err_rail(err_rail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ones(input int v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (v >> k) & 1;
    return n;
  endfunction

  function automatic int ref_next(input int s);
    int info = s >> 1;
    int fb = ((info >> 3) ^ info) & 1;
    info = ((info << 1) | fb) & 15;
    return (info << 1) | (ones(info) & 1);
  endfunction

  task automatic expect_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock edge: apply current inputs to the model, then land on the falling edge
  task automatic edge_step();
    @(posedge clk);
    if (rst) ref_s = SEED_W;
    else if (load_en) begin
      if (load_word != 0 && (ones(load_word) % 2) == 0) ref_s = load_word;
    end
    else if (step_en) ref_s = ref_next(ref_s);
    @(negedge clk);
  endtask

  // compare observed word and rails against the model
  task automatic compare(input string req);
    int obs, ra, rb, exp_r;
    #1;
    obs = (ref_s & ~int'(flt_state_en)) | (int'(flt_state_val) & int'(flt_state_en));
    ra = ones(obs & 3) & 1;
    rb = ~(ones(obs >> 2) & 1) & 1;
    if (flt_rail_en[0]) ra = flt_rail_val[0];
    if (flt_rail_en[1]) rb = flt_rail_val[1];
    exp_r = (rb << 1) | ra;
    expect_val(req, {25'b0, state_q, err_rail}, (obs << 2) | exp_r);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen[$];
    int bad;
    @(negedge clk);
    rst = 1'b1;
    edge_step();
    rst = 1'b0;
    compare("R1");
    expect_val("R1 seed", state_q, SEED_W);
    expect_val("R7 valid rails", int'(err_rail[1] != err_rail[0]), 1);

    // R3: full ring walk
    step_en = 1'b1;
    seen.push_back(int'(state_q));
    for (int i = 0; i < 15; i++) begin
      edge_step();
      compare("R3");
      expect_val("R2 codeword", int'(state_q != 0 && ones(state_q) % 2 == 0), 1);
      if (i < 14) begin
        foreach (seen[j]) if (seen[j] == int'(state_q))
          expect_val("R3 no repeat", state_q, -1);
        seen.push_back(int'(state_q));
      end
    end
    expect_val("R3 period 15", state_q, SEED_W);
    expect_val("R3 distinct count", seen.size(), 15);

    // R4: hold
    step_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      edge_step();
      compare("R4");
    end

    // R5: valid load beats step
    step_en = 1'b1;
    load_en = 1'b1;
    load_word = 5'b10100;
    edge_step();
    compare("R5");
    expect_val("R5 loaded", state_q, 5'b10100);

    // R6: zero and odd-weight loads rejected
    load_word = 5'b00000;
    edge_step();
    compare("R6");
    expect_val("R6 zero kept", state_q, 5'b10100);
    load_word = 5'b00001;
    edge_step();
    compare("R6");
    expect_val("R6 odd kept", state_q, 5'b10100);
    load_en = 1'b0;
    edge_step();
    compare("R3");

    // R8: single observed-bit flips
    step_en = 1'b0;
    for (int b = 0; b < 5; b++) begin
      flt_state_en = 5'(1 << b);
      flt_state_val = ~5'(ref_s);
      compare("R8");
      expect_val("R8 rails equal", int'(err_rail[1] == err_rail[0]), 1);
      edge_step();
    end
    flt_state_en = '0;
    compare("R10");
    expect_val("R10 stored intact", int'(state_q), ref_s);

    // R10: stepping under a state fault is unaffected
    step_en = 1'b1;
    flt_state_en = 5'b00100;
    flt_state_val = 5'b00000;
    for (int i = 0; i < 4; i++) begin
      edge_step();
      compare("R10");
    end
    flt_state_en = '0;
    compare("R10");

    // R9: each rail stuck at each value is exposed during the ring
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 2; v++) begin
        flt_rail_en = 2'(1 << r);
        flt_rail_val = {1'(v), 1'(v)};
        bad = 0;
        for (int i = 0; i < 15; i++) begin
          edge_step();
          compare("R9");
          if (err_rail[1] == err_rail[0]) bad++;
        end
        expect_val("R9 rail fault seen", int'(bad > 0), 1);
      end
    end
    flt_rail_en = '0;
    compare("R7");

    // R1 again from mid-ring
    rst = 1'b1;
    edge_step();
    rst = 1'b0;
    compare("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule